// File: doc/BRIEF.md
# Ring-Qualified Power Mode Sequencer

This block chooses the operating mode of a caller-identification receiver. Two already-digitized control levels set the mode: a power-down request and a ring-timing level, which an external RC network pulls low while ringing is present. With both levels high the receiver is off. A low ring-timing level with the power-down request still high gives a partial mode, in which only the ring analyser runs. A low power-down request gives full power. The demodulator is enabled only once a programmable oscillator settle time has passed after full power begins.

The ring analyser looks at a digitized ring pulse stream. It checks the spacing of rising edges against a period window and drives an active-low ring-valid flag once in-window pulses have continued for a qualification interval. The flag stays low until no pulse edge has arrived for a hold interval. If the flag is wired back to the power-down request input, a qualified ring raises the receiver to full power by itself. The receiver drops back to off once the ring has ended and ring-timing has returned high.

Top module: `ring_pwr_seq`

## Requirements
- R1: With the power-down request high and ring-timing high, the mode output is 2'b00 (off), and both enables are low.
- R2: With the power-down request high and ring-timing low, the mode output is 2'b01 (partial): the ring analyser enable is high and the demodulator enable stays low for any length of time.
- R3: With the power-down request low, the mode output is 2'b10 (full) whatever ring-timing does, and the mode value 2'b11 never appears.
- R4: When the power-down request returns high while ring-timing is high, the mode goes back to off and the demodulator enable falls.
- R5: The demodulator enable rises exactly SETTLE_CYC cycles after the mode output first shows full, and is low in every other mode.
- R6: Each control level passes through two flops, so a change driven before a rising edge reaches the mode output after the second rising edge.
- R7: The ring-valid output (low = valid) falls only after ring-pulse rising edges spaced between PER_MIN_CYC and PER_MAX_CYC cycles have continued for at least QUAL_CYC cycles. Spacing that is too short or too long restarts qualification.
- R8: Once low, the ring-valid output stays low while pulses continue, and returns high after about HOLD_CYC cycles without a pulse edge.
- R9: In off mode the ring analyser is held cleared: the ring-valid output is high, pulses are ignored, and no progress carries into a later partial mode.
- R10: With the ring-valid output fed back to the power-down request input, a qualified ring in partial mode brings the block to full. When the ring stops and ring-timing is high, the block returns to off.
- R11: After reset the mode is off, both enables are low and the ring-valid output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| pwrdn_req_i | input | 1 | Power-down request level (high = request power-down) |
| ring_time_i | input | 1 | Ring-timing level (low = ringing energy present) |
| ring_pulse_i | input | 1 | Digitized ring pulse stream |
| mode_o | output | 2 | Current mode: 00 off, 01 partial, 10 full |
| ring_en_o | output | 1 | Ring analyser enable |
| demod_en_o | output | 1 | Demodulator enable |
| ring_ok_no | output | 1 | Ring-valid flag, active low |

## Verification
A stuck or wrong synchronizer stage shows up on the mode output one edge early or late, right after a control level changes. A wrong settle count moves the demodulator enable edge away from the exact settle cycle. A qualifier that keeps its run count across a bad interval or across off mode lowers the ring-valid flag too early. That happens within one pulse period of the qualification interval. A hold counter that does not restart at each edge releases the flag while pulses are still arriving.

// File: rtl/ring_pwr_pkg.sv
package ring_pwr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_PART = 2'b01,
    MODE_FULL = 2'b10
  } pmode_e;
endpackage

// File: rtl/rps_sync.sv
// Two-flop level synchronizer with a selectable reset value.
module rps_sync #(
  parameter int         WIDTH   = 1,
  parameter logic [0:0] RST_VAL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= {WIDTH{RST_VAL}};
      stage2_q <= {WIDTH{RST_VAL}};
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/rps_mode_ctl.sv
// Mode decode from synchronized levels plus oscillator settle timer.
module rps_mode_ctl
  import ring_pwr_pkg::*;
#(
  parameter int SETTLE_CYC = 250_000
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pwrdn_s_i,
  input  logic   rtime_s_i,
  output pmode_e mode_o,
  output logic   ring_en_o,
  output logic   demod_en_o
);
  localparam int SW = $clog2(SETTLE_CYC + 1) + 1;
  localparam logic [SW-1:0] SETTLE_END = SW'(SETTLE_CYC);

  pmode_e        mode;
  logic [SW-1:0] settle_q, settle_d;

  always_comb begin
    if (!pwrdn_s_i)      mode = MODE_FULL;
    else if (!rtime_s_i) mode = MODE_PART;
    else                 mode = MODE_OFF;
  end

  always_comb begin
    settle_d = settle_q;
    if (mode != MODE_FULL)        settle_d = '0;
    else if (settle_q != SETTLE_END) settle_d = settle_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) settle_q <= '0;
    else         settle_q <= settle_d;
  end

  assign mode_o     = mode;
  assign ring_en_o  = (mode != MODE_OFF);
  assign demod_en_o = (mode == MODE_FULL) && (settle_q == SETTLE_END);
endmodule

// File: rtl/rps_ring_qual.sv
// Ring burst qualifier: period window, persistence and release hold.
module rps_ring_qual #(
  parameter int PER_MIN_CYC = 1_838_235,
  parameter int PER_MAX_CYC = 8_333_333,
  parameter int QUAL_CYC    = 12_500_000,
  parameter int HOLD_CYC    = 25_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pulse_s_i,
  output logic valid_o
);
  localparam int TOP = (HOLD_CYC > QUAL_CYC) ? HOLD_CYC : QUAL_CYC;
  localparam int CW  = $clog2(TOP + 1) + 1;
  localparam logic [CW-1:0] GAP_LO   = CW'(PER_MIN_CYC - 1);
  localparam logic [CW-1:0] GAP_HI   = CW'(PER_MAX_CYC - 1);
  localparam logic [CW-1:0] QUAL_END = CW'(QUAL_CYC);
  localparam logic [CW-1:0] HOLD_END = CW'(HOLD_CYC);

  logic          pulse_d_q;
  logic [CW-1:0] gap_q, gap_d;
  logic [CW-1:0] run_q, run_d;
  logic          flag_q, flag_d;
  logic          rise, in_window;

  assign rise      = pulse_s_i & ~pulse_d_q;
  assign in_window = (gap_q >= GAP_LO) && (gap_q <= GAP_HI);

  always_comb begin
    gap_d  = gap_q;
    run_d  = run_q;
    flag_d = flag_q;
    if (!en_i) begin
      gap_d  = HOLD_END;
      run_d  = '0;
      flag_d = 1'b0;
    end else begin
      if (rise)                  gap_d = '0;
      else if (gap_q != HOLD_END) gap_d = gap_q + 1'b1;

      if (rise && !in_window)     run_d = '0;
      else if (run_q != QUAL_END) run_d = run_q + 1'b1;

      if (flag_q) flag_d = rise || (gap_q != HOLD_END);
      else        flag_d = rise && in_window && (run_q >= QUAL_END);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_d_q <= 1'b0;
      gap_q     <= HOLD_END;
      run_q     <= '0;
      flag_q    <= 1'b0;
    end else begin
      pulse_d_q <= pulse_s_i;
      gap_q     <= gap_d;
      run_q     <= run_d;
      flag_q    <= flag_d;
    end
  end

  assign valid_o = flag_q;
endmodule

// File: rtl/ring_pwr_seq.sv
// Top: synchronizers, mode control and ring qualifier.
module ring_pwr_seq
  import ring_pwr_pkg::*;
#(
  parameter int SETTLE_CYC  = 250_000,
  parameter int PER_MIN_CYC = 1_838_235,
  parameter int PER_MAX_CYC = 8_333_333,
  parameter int QUAL_CYC    = 12_500_000,
  parameter int HOLD_CYC    = 25_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwrdn_req_i,
  input  logic       ring_time_i,
  input  logic       ring_pulse_i,
  output logic [1:0] mode_o,
  output logic       ring_en_o,
  output logic       demod_en_o,
  output logic       ring_ok_no
);
  logic   rst_n_sync;
  logic   pwrdn_s, rtime_s, pulse_s;
  logic   ring_en, ring_valid;
  pmode_e mode;

  rps_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(rst_n_sync)
  );

  rps_sync #(.WIDTH(2), .RST_VAL(1'b1)) u_ctl_sync (
    .clk_i(clk_i), .rst_ni(rst_n_sync),
    .d_i({pwrdn_req_i, ring_time_i}), .q_o({pwrdn_s, rtime_s})
  );

  rps_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_pulse_sync (
    .clk_i(clk_i), .rst_ni(rst_n_sync), .d_i(ring_pulse_i), .q_o(pulse_s)
  );

  rps_mode_ctl #(.SETTLE_CYC(SETTLE_CYC)) u_mode (
    .clk_i(clk_i), .rst_ni(rst_n_sync),
    .pwrdn_s_i(pwrdn_s), .rtime_s_i(rtime_s),
    .mode_o(mode), .ring_en_o(ring_en), .demod_en_o(demod_en_o)
  );

  rps_ring_qual #(
    .PER_MIN_CYC(PER_MIN_CYC), .PER_MAX_CYC(PER_MAX_CYC),
    .QUAL_CYC(QUAL_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_qual (
    .clk_i(clk_i), .rst_ni(rst_n_sync),
    .en_i(ring_en), .pulse_s_i(pulse_s), .valid_o(ring_valid)
  );

  assign mode_o     = mode;
  assign ring_en_o  = ring_en;
  assign ring_ok_no = ~ring_valid;
endmodule

// File: rtl/ring_pwr_seq_chk.sv
module ring_pwr_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_o,
  input logic       ring_en_o,
  input logic       demod_en_o,
  input logic       ring_ok_no
);
  // R1, R9: off for two cycles leaves the flag inactive and demod off
  a_r1_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00 && $past(mode_o) == 2'b00) |-> (ring_ok_no && !demod_en_o));

  // R2: partial mode never enables the demodulator
  a_r2_partial_no_demod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b01) |-> !demod_en_o);

  // R3: unused mode encoding never appears
  a_r3_mode_encoding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);

  // R5: demodulator enable only rises after full mode was already present
  a_r5_demod_after_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(demod_en_o) |-> ($past(mode_o) == 2'b10));

  // R9: a valid ring flag requires the analyser to have been running
  a_r9_flag_needs_analyser: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ring_ok_no |-> $past(ring_en_o));
endmodule

bind ring_pwr_seq ring_pwr_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_o(mode_o),
  .ring_en_o(ring_en_o), .demod_en_o(demod_en_o), .ring_ok_no(ring_ok_no)
);

// File: tb/ring_pwr_seq_bench.sv
module ring_pwr_seq_bench;
  localparam int SETTLE = 20;
  localparam int PMIN   = 10;
  localparam int PMAX   = 40;
  localparam int QUAL   = 100;
  localparam int HOLD   = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_drv = 1'b1, rt = 1'b1, ring = 1'b0, loop_en = 1'b0;
  logic pd_in;
  logic [1:0] mode;
  logic ring_en, demod_en, ok_n;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  assign pd_in = loop_en ? ok_n : pd_drv;

  ring_pwr_seq #(
    .SETTLE_CYC(SETTLE), .PER_MIN_CYC(PMIN), .PER_MAX_CYC(PMAX),
    .QUAL_CYC(QUAL), .HOLD_CYC(HOLD)
  ) u_ring_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .pwrdn_req_i(pd_in), .ring_time_i(rt),
    .ring_pulse_i(ring), .mode_o(mode), .ring_en_o(ring_en),
    .demod_en_o(demod_en), .ring_ok_no(ok_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n, input int per);
    for (int i = 0; i < n; i++) begin
      ring = 1'b1; cyc(3);
      ring = 1'b0; cyc(per - 3);
    end
  endtask

  task automatic go_off();
    loop_en = 1'b0; pd_drv = 1'b1; rt = 1'b1; ring = 1'b0; cyc(6);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic t_reset();
    cyc(6);
    chk("R11 mode", mode, 2'b00);
    chk("R11 ring_en", ring_en, 1'b0);
    chk("R11 demod_en", demod_en, 1'b0);
    chk("R11 ring_ok_n", ok_n, 1'b1);
    chk("R1 off ring_en", ring_en, 1'b0);
  endtask

  task automatic t_sync_latency();
    pd_drv = 1'b0;
    cyc(1); chk("R6 one edge still off", mode, 2'b00);
    cyc(1); chk("R6 two edges full", mode, 2'b10);
    go_off();
  endtask

  task automatic t_full_ignores_rt();
    pd_drv = 1'b0; cyc(4);
    chk("R3 full rt high", mode, 2'b10);
    rt = 1'b0; cyc(4);
    chk("R3 full rt low", mode, 2'b10);
    rt = 1'b1; cyc(4);
    chk("R3 full rt high again", mode, 2'b10);
    go_off();
  endtask

  task automatic t_settle();
    logic early = 1'b0;
    pd_drv = 1'b0;
    while (mode != 2'b10) @(negedge clk);
    chk("R5 demod low at full entry", demod_en, 1'b0);
    for (int i = 1; i < SETTLE; i++) begin
      @(negedge clk);
      if (demod_en) early = 1'b1;
    end
    chk("R5 demod low during settle", early, 1'b0);
    cyc(1);
    chk("R5 demod high at settle end", demod_en, 1'b1);
    chk("R3 ring_en in full", ring_en, 1'b1);
  endtask

  task automatic t_return_off();
    pd_drv = 1'b1; rt = 1'b1; cyc(2);
    chk("R4 back to off", mode, 2'b00);
    chk("R4 demod dropped", demod_en, 1'b0);
    chk("R1 ring_en low", ring_en, 1'b0);
  endtask

  task automatic t_partial();
    rt = 1'b0; cyc(2 + 3 * SETTLE);
    chk("R2 mode partial", mode, 2'b01);
    chk("R2 ring_en", ring_en, 1'b1);
    chk("R2 demod stays low", demod_en, 1'b0);
  endtask

  task automatic t_qualify_and_hold();
    pulses(6, 20);
    chk("R7 not yet qualified", ok_n, 1'b1);
    pulses(2, 20);
    chk("R7 qualified", ok_n, 1'b0);
    pulses(6, 20);
    chk("R8 held while pulsing", ok_n, 1'b0);
    cyc(HOLD - 40);
    chk("R8 held before timeout", ok_n, 1'b0);
    cyc(50);
    chk("R8 released after timeout", ok_n, 1'b1);
    go_off();
  endtask

  task automatic t_bad_rate();
    rt = 1'b0; cyc(4);
    pulses(12, 60);
    chk("R7 slow pulses rejected", ok_n, 1'b1);
    pulses(25, 8);
    chk("R7 fast pulses rejected", ok_n, 1'b1);
    pulses(5, 20); pulses(1, 60); pulses(3, 20);
    chk("R7 gap restarts qualification", ok_n, 1'b1);
    go_off();
  endtask

  task automatic t_off_ignores();
    pulses(10, 20);
    chk("R9 off flag high", ok_n, 1'b1);
    chk("R9 off ring_en low", ring_en, 1'b0);
    rt = 1'b0; cyc(4);
    pulses(3, 20);
    chk("R9 no carried progress", ok_n, 1'b1);
    pulses(6, 20);
    chk("R7 qualified in partial", ok_n, 1'b0);
    rt = 1'b1; cyc(4);
    chk("R9 off clears flag", ok_n, 1'b1);
    go_off();
  endtask

  task automatic t_loopback();
    loop_en = 1'b1; rt = 1'b0; cyc(4);
    chk("R10 partial before ring", mode, 2'b01);
    pulses(8, 20);
    cyc(3);
    chk("R10 auto full", mode, 2'b10);
    rt = 1'b1; cyc(HOLD - 60);
    chk("R10 full while flag held", mode, 2'b10);
    cyc(80);
    chk("R10 back to off", mode, 2'b00);
    go_off();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_sync_latency();
    t_full_ignores_rt();
    t_settle();
    t_return_off();
    t_partial();
    t_qualify_and_hold();
    t_bad_rate();
    t_off_ignores();
    t_loopback();
    report();
    $finish;
  end
endmodule